// File: doc/BRIEF.md
# Two-Half Graphic LCD Text Writer

This block drives a 128x64 monochrome graphic LCD built from two 64x64 panel halves. Each half has its own active-low select. The LCD has an 8-bit write bus, an instruction/data select, a read/write line, an enable strobe and an active-low reset. A command port takes one command at a time. The commands are: initialise the panel, clear it, set the scroll start line, and print one character whose eight column bytes arrive on a 64-bit glyph input.

The block keeps a 16x8 text cursor. For each character it works out the panel half and the local column. It then sends a page instruction and a column instruction, followed by the eight glyph bytes as vertical 8-pixel strips. The LCD's busy flag is never read. Fixed strobe timing and a fixed reset pulse length take its place. A host holds `cmd_valid` with an opcode. It then waits for the one-cycle `done` pulse.

Top module: `glcd_text_writer`

## Requirements
- R1: While reset is asserted and just after it is released, `busy`, `done`, `lcd_en` and `lcd_rw` are 0, and `lcd_csl_n`, `lcd_csr_n` and `lcd_rst_n` are 1.
- R2: Opcodes are 0 = init, 1 = clear, 2 = scroll, 3 = print. A command is accepted at a clock edge where `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle until the command ends. `done` is high for exactly one cycle, and `busy` falls in the cycle after `done`.
- R3: Every byte transfer holds `lcd_en` low for at least PHASE clocks and then high for exactly PHASE clocks. Data, the instruction/data select and both selects are stable while `lcd_en` is high.
- R4: Init drives `lcd_rst_n` low for exactly RST_CYC cycles with both halves deselected. It then writes instruction 0x3F (select = 0) to both halves and homes the cursor to column 0, row 0.
- R5: Clear works through pages 0 to 7 in order, with both halves selected. Each page gets instruction 0xB8+page, then instruction 0x40, then 64 data bytes of 0x00 (select = 1).
- R6: Scroll writes instruction 0xC0+line to both halves, where `cmd_line` is 0 to 63.
- R7: Print selects only the half that holds pixel column X*8. A value below 64 gives the left half (`lcd_csl_n` low). Otherwise it gives the right half at X*8-64. Print first writes instruction 0xB8+Y and then 0x40+local column.
- R8: After the two instructions, print writes eight data bytes (select = 1), starting with `cmd_glyph[7:0]` and ending with `cmd_glyph[63:56]`. The bytes come from the glyph latched at acceptance.
- R9: After each print, X advances. After 15, X wraps to 0 and Y advances. After 7, Y wraps to 0.
- R10: `lcd_rw` is always 0. Both selects are high and `lcd_en` is low whenever no command is in progress.
- R11: A command presented while `busy` is high is ignored. It produces no LCD traffic and does not move the cursor. Changing the glyph input during a print does not alter the bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode (0 init, 1 clear, 2 scroll, 3 print) |
| cmd_line | input | 6 | Scroll start line |
| cmd_glyph | input | 64 | Eight glyph column bytes, byte 0 leftmost |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| lcd_data | output | 8 | LCD data bus |
| lcd_di | output | 1 | 0 = instruction, 1 = display data |
| lcd_rw | output | 1 | Read/write line, held at write |
| lcd_en | output | 1 | Enable strobe |
| lcd_csl_n | output | 1 | Left half select, active low |
| lcd_csr_n | output | 1 | Right half select, active low |
| lcd_rst_n | output | 1 | LCD reset, active low |

## Verification
`busy` is due in the first cycle after the accepting edge, so the bench checks it at the next falling edge. `done` is checked one cycle after it is seen high. The first LCD byte appears PHASE+1 cycles after acceptance, or PHASE+1 cycles after `lcd_rst_n` rises for init. Each following byte appears 2*PHASE+1 cycles after the previous one. The bench does not predict these edges. A scoreboard queue receives the expected bytes before each command is issued. A monitor compares the bytes as each rising `lcd_en` is seen at a falling clock edge. The monitor also measures each enable phase and the reset pulse in whole cycles. Any traffic beyond the queued bytes is reported as a failure.

// File: rtl/gtw_pkg.sv
// Shared opcodes, LCD instruction bases and the byte descriptor.
// Assumes a write-only LCD link; nothing is read back from the panel.
package gtw_pkg;
    typedef enum logic [1:0] {
        OP_INIT   = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SCROLL = 2'd2,
        OP_PUTC   = 2'd3
    } op_e;

    localparam logic [7:0] INS_ON   = 8'h3F;
    localparam logic [7:0] INS_PAGE = 8'hB8;
    localparam logic [7:0] INS_COL  = 8'h40;
    localparam logic [7:0] INS_LINE = 8'hC0;

    typedef struct packed {
        logic       csl_n;
        logic       csr_n;
        logic       di;
        logic [7:0] data;
    } lcd_byte_t;
endpackage

// File: rtl/gtw_strobe.sv
// Byte strobe engine: latches one LCD byte and plays an enable-low phase,
// then an enable-high phase, each PHASE clocks long. Both selects read as
// deselected while the engine is idle. Assumes start only arrives when idle.
module gtw_strobe
    import gtw_pkg::*;
#(
    parameter int PHASE = 23
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  lcd_byte_t byte_in,
    output lcd_byte_t byte_out,
    output logic      en,
    output logic      fin
);
    localparam int CW = $clog2(PHASE + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_e;

    st_e       st;
    logic [CW-1:0] cnt;
    lcd_byte_t bus_q;

    // Phase sequencer: idle -> enable low -> enable high -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            bus_q <= '{csl_n: 1'b1, csr_n: 1'b1, di: 1'b0, data: 8'h00};
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st    <= ST_LO;
                    cnt   <= '0;
                    bus_q <= byte_in;
                end
                ST_LO: if (cnt == CW'(PHASE - 1)) begin
                    st  <= ST_HI;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                default: if (cnt == CW'(PHASE - 1)) begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
            endcase
        end
    end

    // Output view: selects forced inactive between transfers.
    always_comb begin
        byte_out = bus_q;
        if (st == ST_IDLE) begin
            byte_out.csl_n = 1'b1;
            byte_out.csr_n = 1'b1;
        end
    end

    assign en  = (st == ST_HI);
    assign fin = (st == ST_HI) && (cnt == CW'(PHASE - 1));

    assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == ST_IDLE));
endmodule

// File: rtl/gtw_cursor.sv
// Text cursor of COLS x ROWS cells. Home forces 0,0; advance steps X and
// carries into Y, both wrapping. Assumes home and advance are not coincident.
module gtw_cursor #(
    parameter int COLS = 16,
    parameter int ROWS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    home,
    input  logic                    adv,
    output logic [$clog2(COLS)-1:0] cx,
    output logic [$clog2(ROWS)-1:0] cy
);
    localparam int XW = $clog2(COLS);
    localparam int YW = $clog2(ROWS);

    // Cursor update with wrap of both coordinates.
    always_ff @(posedge clk) begin
        if (!rst_n || home) begin
            cx <= '0;
            cy <= '0;
        end else if (adv) begin
            if (cx == XW'(COLS - 1)) begin
                cx <= '0;
                cy <= (cy == YW'(ROWS - 1)) ? '0 : cy + 1'b1;
            end else begin
                cx <= cx + 1'b1;
            end
        end
    end

    assert_xwrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !home && cx == XW'(COLS - 1)) |=> (cx == '0));
endmodule

// File: rtl/gtw_bytegen.sv
// Combinational byte source: from the current command, the page/step
// counters and the cursor, forms the next LCD byte and flags the last one.
// Assumes k never exceeds the last step of the active command.
module gtw_bytegen
    import gtw_pkg::*;
#(
    parameter int COLS      = 16,
    parameter int PAGES     = 8,
    parameter int HALF_COLS = 64,
    parameter int GLYPH_W   = 8
) (
    input  op_e                             op,
    input  logic [$clog2(PAGES)-1:0]        pg,
    input  logic [$clog2(HALF_COLS+2)-1:0]  k,
    input  logic [$clog2(COLS)-1:0]         cx,
    input  logic [$clog2(PAGES)-1:0]        cy,
    input  logic [$clog2(HALF_COLS)-1:0]    line,
    input  logic [GLYPH_W*8-1:0]            glyph,
    output lcd_byte_t                       b,
    output logic                            last
);
    localparam int KW  = $clog2(HALF_COLS + 2);
    localparam int LW  = $clog2(HALF_COLS);
    localparam int PXW = $clog2(COLS * GLYPH_W);
    localparam int GIW = $clog2(GLYPH_W);

    logic [PXW-1:0] px;
    logic           right;
    logic [LW-1:0]  col;
    logic [GIW-1:0] gi;

    // Panel half and local column of the cursor cell.
    always_comb begin
        px    = PXW'(cx) * PXW'(GLYPH_W);
        right = (px >= PXW'(HALF_COLS));
        col   = right ? LW'(px - PXW'(HALF_COLS)) : LW'(px);
        gi    = GIW'(k - KW'(2));
    end

    // Byte selection per command and step.
    always_comb begin
        b    = '{csl_n: 1'b0, csr_n: 1'b0, di: 1'b0, data: 8'h00};
        last = 1'b0;
        case (op)
            OP_INIT: begin
                b.data = INS_ON;
                last   = 1'b1;
            end
            OP_CLEAR: begin
                if (k == '0)           b.data = INS_PAGE + 8'(pg);
                else if (k == KW'(1))  b.data = INS_COL;
                else                   b.di   = 1'b1;
                last = (pg == $clog2(PAGES)'(PAGES - 1)) && (k == KW'(HALF_COLS + 1));
            end
            OP_SCROLL: begin
                b.data = INS_LINE + 8'(line);
                last   = 1'b1;
            end
            default: begin
                b.csl_n = right;
                b.csr_n = !right;
                if (k == '0)          b.data = INS_PAGE + 8'(cy);
                else if (k == KW'(1)) b.data = INS_COL + 8'(col);
                else begin
                    b.di   = 1'b1;
                    b.data = glyph[gi*8 +: 8];
                end
                last = (k == KW'(GLYPH_W + 1));
            end
        endcase
    end
endmodule

// File: rtl/glcd_text_writer.sv
// Top: command handshake and step sequencer for a two-half graphic LCD.
// Init pulses the LCD reset then turns the panel on; clear, scroll and print
// stream bytes through the strobe engine. Assumes a write-only panel and
// fixed timing in place of busy polling.
module glcd_text_writer
    import gtw_pkg::*;
#(
    parameter int PHASE     = 23,
    parameter int RST_CYC   = 25000,
    parameter int COLS      = 16,
    parameter int ROWS      = 8,
    parameter int HALF_COLS = 64,
    parameter int GLYPH_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_op,
    input  logic [$clog2(HALF_COLS)-1:0] cmd_line,
    input  logic [GLYPH_W*8-1:0]         cmd_glyph,
    output logic                         busy,
    output logic                         done,
    output logic [7:0]                   lcd_data,
    output logic                         lcd_di,
    output logic                         lcd_rw,
    output logic                         lcd_en,
    output logic                         lcd_csl_n,
    output logic                         lcd_csr_n,
    output logic                         lcd_rst_n
);
    localparam int PAGES = ROWS;
    localparam int PW    = $clog2(PAGES);
    localparam int KW    = $clog2(HALF_COLS + 2);
    localparam int LW    = $clog2(HALF_COLS);
    localparam int RCW   = $clog2(RST_CYC + 1);

    typedef enum logic [1:0] {S_IDLE, S_RST, S_XFER, S_DONE} seq_e;

    seq_e                st;
    op_e                 op_q;
    logic [LW-1:0]       line_q;
    logic [GLYPH_W*8-1:0] glyph_q;
    logic [PW-1:0]       pg;
    logic [KW-1:0]       k;
    logic [RCW-1:0]      rcnt;
    logic                kick;
    logic                accept, fin, last, adv, home;
    lcd_byte_t           nxt, cur;
    logic [$clog2(COLS)-1:0] cx;
    logic [PW-1:0]       cy;

    assign accept = (st == S_IDLE) && cmd_valid;
    assign home   = accept && (op_e'(cmd_op) == OP_INIT);
    assign adv    = (st == S_XFER) && fin && last && (op_q == OP_PUTC);

    // Command sequencer: accept, reset pulse, byte stream, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            op_q    <= OP_INIT;
            line_q  <= '0;
            glyph_q <= '0;
            pg      <= '0;
            k       <= '0;
            rcnt    <= '0;
            kick    <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (accept) begin
                    op_q    <= op_e'(cmd_op);
                    line_q  <= cmd_line;
                    glyph_q <= cmd_glyph;
                    pg      <= '0;
                    k       <= '0;
                    rcnt    <= '0;
                    if (op_e'(cmd_op) == OP_INIT) st <= S_RST;
                    else begin
                        st   <= S_XFER;
                        kick <= 1'b1;
                    end
                end
                S_RST: if (rcnt == RCW'(RST_CYC - 1)) begin
                    st   <= S_XFER;
                    kick <= 1'b1;
                end else rcnt <= rcnt + 1'b1;
                S_XFER: begin
                    kick <= 1'b0;
                    if (fin) begin
                        if (last) st <= S_DONE;
                        else begin
                            kick <= 1'b1;
                            if (op_q == OP_CLEAR && k == KW'(HALF_COLS + 1)) begin
                                k  <= '0;
                                pg <= pg + 1'b1;
                            end else k <= k + 1'b1;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    gtw_cursor #(.COLS(COLS), .ROWS(ROWS)) cursor_i (
        .clk(clk), .rst_n(rst_n), .home(home), .adv(adv), .cx(cx), .cy(cy)
    );

    gtw_bytegen #(.COLS(COLS), .PAGES(PAGES), .HALF_COLS(HALF_COLS), .GLYPH_W(GLYPH_W)) gen_i (
        .op(op_q), .pg(pg), .k(k), .cx(cx), .cy(cy), .line(line_q),
        .glyph(glyph_q), .b(nxt), .last(last)
    );

    gtw_strobe #(.PHASE(PHASE)) strobe_i (
        .clk(clk), .rst_n(rst_n), .start(kick), .byte_in(nxt),
        .byte_out(cur), .en(lcd_en), .fin(fin)
    );

    assign busy      = (st != S_IDLE);
    assign done      = (st == S_DONE);
    assign lcd_rst_n = (st != S_RST);
    assign lcd_rw    = 1'b0;
    assign lcd_data  = cur.data;
    assign lcd_di    = cur.di;
    assign lcd_csl_n = cur.csl_n;
    assign lcd_csr_n = cur.csr_n;

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |=> (!lcd_en || $stable({lcd_data, lcd_di, lcd_csl_n, lcd_csr_n})));
    assert_rst_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (lcd_csl_n && lcd_csr_n && !lcd_en));
    assert_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lcd_csl_n && lcd_csr_n && !lcd_en));
endmodule

// File: tb/glcd_text_writer_tb_top.sv
// Scoreboard bench: the driver queues expected LCD bytes per command, a
// monitor pops and compares them on each rising enable.
module glcd_text_writer_tb_top;
    localparam int PHASE   = 2;
    localparam int RST_CYC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [5:0]  cmd_line = 6'd0;
    logic [63:0] cmd_glyph = 64'd0;
    logic        busy, done, lcd_di, lcd_rw, lcd_en, lcd_csl_n, lcd_csr_n, lcd_rst_n;
    logic [7:0]  lcd_data;

    int checks = 0;
    int errors = 0;
    logic [11:0] expq[$];
    int bx = 0;
    int by = 0;

    always #10 clk = ~clk;

    glcd_text_writer #(.PHASE(PHASE), .RST_CYC(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_line(cmd_line), .cmd_glyph(cmd_glyph), .busy(busy), .done(done),
        .lcd_data(lcd_data), .lcd_di(lcd_di), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
        .lcd_csl_n(lcd_csl_n), .lcd_csr_n(lcd_csr_n), .lcd_rst_n(lcd_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input bit csl, input bit csr, input bit di, input logic [7:0] d);
        expq.push_back({csl, csr, di, 1'b0, d});
    endtask

    task automatic exp_putc(input logic [63:0] g);
        bit right;
        int col;
        right = (bx * 8) >= 64;
        col = right ? bx * 8 - 64 : bx * 8;
        push(right, !right, 1'b0, 8'(8'hB8 + by));   // R7 page
        push(right, !right, 1'b0, 8'(8'h40 + col));  // R7 column
        for (int i = 0; i < 8; i++) push(right, !right, 1'b1, g[i*8 +: 8]); // R8
        if (bx == 15) begin                          // R9 wrap model
            bx = 0;
            by = (by == 7) ? 0 : by + 1;
        end else bx = bx + 1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R2 done seen", {63'd0, done}, 64'd1);
        @(negedge clk);
        chk(!done && !busy, "R2 done one cycle then idle", {62'd0, done, busy}, 64'd0);
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [5:0] ln, input logic [63:0] g);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_line  = ln;
        cmd_glyph = g;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy, "R2 busy after accept", {63'd0, busy}, 64'd1);
        wait_done();
    endtask

    // Monitor: byte compare, enable phase widths, reset pulse length.
    logic en_prev = 1'b0;
    logic rst_prev = 1'b1;
    int   hi_cnt = 0;
    int   lo_cnt = 0;
    int   rst_cnt = 0;
    logic [11:0] cur_b = '0;
    always @(negedge clk) begin
        logic [11:0] b;
        b = {lcd_csl_n, lcd_csr_n, lcd_di, lcd_rw, lcd_data};
        if (lcd_en && !en_prev) begin
            chk(lo_cnt >= PHASE, "R3 enable low phase", 64'(lo_cnt), 64'(PHASE));
            if (expq.size() == 0) chk(1'b0, "R11 unexpected LCD byte", 64'(b), 64'h0);
            else begin
                logic [11:0] e;
                e = expq.pop_front();
                chk(b == e, "R5/R6/R7/R8/R10 LCD byte", 64'(b), 64'(e));
            end
            cur_b  = b;
            hi_cnt = 1;
        end else if (lcd_en) begin
            hi_cnt++;
            chk(b == cur_b, "R3 bus stable while enable high", 64'(b), 64'(cur_b));
        end
        if (!lcd_en && en_prev) begin
            chk(hi_cnt == PHASE, "R3 enable high phase", 64'(hi_cnt), 64'(PHASE));
            lo_cnt = 1;
        end else if (!lcd_en) lo_cnt++;
        if (!lcd_rst_n) begin
            rst_cnt++;
            if (!(lcd_csl_n && lcd_csr_n))
                chk(1'b0, "R4 selects high during reset", {62'd0, lcd_csl_n, lcd_csr_n}, 64'd3);
        end
        if (lcd_rst_n && !rst_prev) begin
            chk(rst_cnt == RST_CYC, "R4 reset pulse length", 64'(rst_cnt), 64'(RST_CYC));
            rst_cnt = 0;
        end
        en_prev  = lcd_en;
        rst_prev = lcd_rst_n;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, queue=%0d expected=0", expq.size());
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] g;
        repeat (4) @(negedge clk);
        chk({busy, done, lcd_en, lcd_rw, lcd_csl_n, lcd_csr_n, lcd_rst_n} == 7'b0000111,
            "R1 outputs in reset", 64'({busy, done, lcd_en, lcd_rw, lcd_csl_n, lcd_csr_n, lcd_rst_n}), 64'h7);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, lcd_en, lcd_rw, lcd_csl_n, lcd_csr_n, lcd_rst_n} == 7'b0000111,
            "R1 outputs after reset", 64'({busy, done, lcd_en, lcd_rw, lcd_csl_n, lcd_csr_n, lcd_rst_n}), 64'h7);

        // R4: init, panel on to both halves.
        push(1'b0, 1'b0, 1'b0, 8'h3F);
        bx = 0; by = 0;
        run_cmd(2'd0, 6'd0, 64'd0);

        // R7 R8 R9: 129 prints, covering both halves and both wraps.
        for (int c = 0; c < 129; c++) begin
            for (int i = 0; i < 8; i++) g[i*8 +: 8] = 8'(c * 8 + i + 1);
            exp_putc(g);
            run_cmd(2'd3, 6'd0, g);
        end

        // R6: scroll start line 37.
        push(1'b0, 1'b0, 1'b0, 8'hE5);
        run_cmd(2'd2, 6'd37, 64'd0);

        // R5: clear both halves.
        for (int p = 0; p < 8; p++) begin
            push(1'b0, 1'b0, 1'b0, 8'(8'hB8 + p));
            push(1'b0, 1'b0, 1'b0, 8'h40);
            for (int i = 0; i < 64; i++) push(1'b0, 1'b0, 1'b1, 8'h00);
        end
        run_cmd(2'd1, 6'd0, 64'd0);

        // R11: commands and glyph changes during a print are ignored.
        g = 64'hA1B2C3D4E5F60718;
        exp_putc(g);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_glyph = g;
        @(negedge clk);
        chk(busy, "R2 busy after accept", {63'd0, busy}, 64'd1);
        cmd_op = 2'd2; cmd_line = 6'd5; cmd_glyph = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        chk(expq.size() == 0, "R11 no extra traffic after ignored command", 64'(expq.size()), 64'd0);
        g = 64'h0102040810204080;
        exp_putc(g);
        run_cmd(2'd3, 6'd0, g);

        // R4: re-init homes the cursor.
        push(1'b0, 1'b0, 1'b0, 8'h3F);
        run_cmd(2'd0, 6'd0, 64'd0);
        bx = 0; by = 0;
        g = 64'h55AA55AA55AA55AA;
        exp_putc(g);
        run_cmd(2'd3, 6'd0, g);

        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R2 all expected bytes produced", 64'(expq.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule